// File: doc/BRIEF.md
# Multistage Omega Switching Fabric

This block moves packets between N source ports and N destination ports of an indirect network. The network is built from log2(N) identical columns of 2x2 switch elements. A perfect-shuffle wiring stands in front of every column. Each packet carries a destination tag and a payload. In every column, one bit of the tag selects the upper or lower output of the element the packet is in. There is exactly one path from each source to each destination.

Both sides use valid/ready handshakes. Each element output has a small FIFO. Two inputs of one element can want the same output in the same cycle. When that happens, a round-robin arbiter lets one through and holds the other back by keeping its ready low. A full FIFO also holds back the column before it. As a result, a blocked destination port fills the buffers behind it without losing or duplicating any packet.

Top module: `omega_fabric`

## Requirements
- R1: A packet always leaves at the destination port whose index equals its tag, and a valid output never shows a tag other than its own port index.
- R2: The tag and the payload leave the fabric bit for bit as they entered.
- R3: Under any mix of traffic, including every source aiming at one port, each accepted packet is delivered exactly once.
- R4: When both inputs of an element keep requesting the same output, the grants alternate between them. Inputs 0 and 4 of an 8-port fabric meet in the first element, so their packets to a shared port arrive alternately.
- R5: While out_ready of a port is low, its out_valid stays high and its tag and data stay unchanged, and nothing is dropped.
- R6: After reset all out_valid lines are low, and a packet offered at an input is accepted on the first clock edge.
- R7: Column i routes on tag bit (n-1-i), where 0 selects the upper output and 1 the lower. With an empty fabric, a packet accepted at one clock edge shows out_valid after the n-th edge, counting the accepting edge as the first (n = log2 N = 3 by default).
- R8: Packets from one source to one destination arrive in the order they were sent.
- R9: Data bits are in_data[p*DATA_W +: DATA_W] and tag bits are in_tag[p*TAG_W +: TAG_W] for port p, and the outputs use the same layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | N_PORTS | Packet offered at each source port |
| in_ready | output | N_PORTS | Source packet taken on this edge |
| in_tag | input | N_PORTS*TAG_W | Destination tag for each source |
| in_data | input | N_PORTS*DATA_W | Payload for each source |
| out_valid | output | N_PORTS | Packet present at each destination |
| out_ready | input | N_PORTS | Destination takes its packet |
| out_tag | output | N_PORTS*TAG_W | Tag of each delivered packet |
| out_data | output | N_PORTS*DATA_W | Payload of each delivered packet |

## Verification
The bench targets four corner cases.

The first is all eight sources aiming at one port. A fabric that mishandled a conflict would drop or repeat a packet there.

The second is two sources streaming into the same element output. A fixed-priority arbiter would drain one stream completely before the other, so the arrivals would not alternate.

The third is a destination held not-ready for many cycles. Here a FIFO that overwrote its head, or let it change, shows up as a changing output or a missing packet.

The fourth is the unloaded latency and a set of permutations. A miswired shuffle, or a column that used the wrong tag bit, would deliver packets to the wrong port or show the wrong delay.

// File: rtl/omega_pkg.sv
package omega_pkg;
   // Inverse perfect shuffle: rotate a BITS-wide position right by one.
   function automatic int unshuffle_pos(input int pos, input int bits);
      return (pos >> 1) | ((pos & 1) << (bits - 1));
   endfunction
endpackage

// File: rtl/omega_fifo.sv
module omega_fifo #(
   parameter int W     = 11,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   output logic         full,
   output logic         rd_valid,
   output logic [W-1:0] rd_data,
   input  logic         rd_en
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("omega_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] rd_ptr, wr_ptr;
   logic [CNT_W-1:0] count;
   logic             push, pop;

   assign full     = (count == CNT_W'(DEPTH));
   assign rd_valid = (count != '0);
   assign rd_data  = mem[rd_ptr];
   assign push     = wr_en & ~full;
   assign pop      = rd_valid & rd_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) begin
            wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         end
         if (pop) begin
            rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
         end
         count <= count + CNT_W'(push) - CNT_W'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= wr_data;
   end

   // R3: the feeding element never writes into a full buffer.
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && full));

   // R5: an unread head stays put.
   p_head_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_en) |=> (rd_valid && $stable(rd_data)));
endmodule

// File: rtl/omega_switch.sv
module omega_switch #(
   parameter int PKT_W      = 11,
   parameter int SEL_POS    = 10,
   parameter int FIFO_DEPTH = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            in_valid,
   input  logic [1:0][PKT_W-1:0] in_pkt,
   output logic [1:0]            in_ready,
   output logic [1:0]            out_valid,
   output logic [1:0][PKT_W-1:0] out_pkt,
   input  logic [1:0]            out_ready
);
   if (SEL_POS >= PKT_W) begin : g_bad_sel
      $error("omega_switch: SEL_POS outside packet");
   end

   logic [1:0]       want;          // requested output per input
   logic [1:0][1:0]  req;           // req[o][i]
   logic [1:0][1:0]  gnt;           // gnt[o][i]
   logic [1:0]       winner;        // winning input per output
   logic [1:0]       prefer;        // round-robin pointer per output
   logic [1:0]       full;
   logic [1:0]       push;

   assign want[0] = in_pkt[0][SEL_POS];
   assign want[1] = in_pkt[1][SEL_POS];

   for (genvar o = 0; o < 2; o++) begin : g_out
      assign req[o][0] = in_valid[0] & (want[0] == 1'(o));
      assign req[o][1] = in_valid[1] & (want[1] == 1'(o));
      assign winner[o] = (&req[o]) ? prefer[o] : req[o][1];
      assign gnt[o][0] = req[o][0] & ~winner[o];
      assign gnt[o][1] = req[o][1] &  winner[o];
      assign push[o]   = (|req[o]) & ~full[o];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     prefer[o] <= 1'b0;
         else if (push[o] && (&req[o]))  prefer[o] <= ~winner[o];
      end

      omega_fifo #(.W(PKT_W), .DEPTH(FIFO_DEPTH)) u_buf (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (push[o]),
         .wr_data  (in_pkt[winner[o]]),
         .full     (full[o]),
         .rd_valid (out_valid[o]),
         .rd_data  (out_pkt[o]),
         .rd_en    (out_ready[o])
      );

      // R4: back-to-back contended grants go to different inputs.
      p_rr_alternate_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (push[o] && (&req[o])) |=>
            ((push[o] && (&req[o])) -> (winner[o] != $past(winner[o]))));

      // R7: every packet written here carries this output's select bit.
      p_route_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
         push[o] |-> (in_pkt[winner[o]][SEL_POS] == 1'(o)));
   end

   assign in_ready[0] = (gnt[0][0] & ~full[0]) | (gnt[1][0] & ~full[1]);
   assign in_ready[1] = (gnt[0][1] & ~full[0]) | (gnt[1][1] & ~full[1]);
endmodule

// File: rtl/omega_fabric.sv
module omega_fabric
   import omega_pkg::*;
#(
   parameter int N_PORTS    = 8,
   parameter int DATA_W     = 8,
   parameter int FIFO_DEPTH = 2
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic [N_PORTS-1:0]                       in_valid,
   output logic [N_PORTS-1:0]                       in_ready,
   input  logic [N_PORTS*$clog2(N_PORTS)-1:0]       in_tag,
   input  logic [N_PORTS*DATA_W-1:0]                in_data,
   output logic [N_PORTS-1:0]                       out_valid,
   input  logic [N_PORTS-1:0]                       out_ready,
   output logic [N_PORTS*$clog2(N_PORTS)-1:0]       out_tag,
   output logic [N_PORTS*DATA_W-1:0]                out_data
);
   localparam int STAGES = $clog2(N_PORTS);
   localparam int TAG_W  = STAGES;
   localparam int PKT_W  = TAG_W + DATA_W;
   localparam int HALF   = N_PORTS / 2;

   if (N_PORTS < 2 || (N_PORTS & (N_PORTS - 1)) != 0) begin : g_bad_ports
      $error("omega_fabric: N_PORTS must be a power of two, at least 2");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("omega_fabric: DATA_W must be positive");
   end

   // Level s feeds column s; level STAGES is the destination side.
   logic             lvl_valid [STAGES+1][N_PORTS];
   logic             lvl_ready [STAGES+1][N_PORTS];
   logic [PKT_W-1:0] lvl_pkt   [STAGES+1][N_PORTS];

   for (genvar p = 0; p < N_PORTS; p++) begin : g_edge
      assign lvl_valid[0][p] = in_valid[p];
      assign lvl_pkt[0][p]   = {in_tag[p*TAG_W +: TAG_W], in_data[p*DATA_W +: DATA_W]};
      assign in_ready[p]     = lvl_ready[0][p];

      assign out_valid[p]                  = lvl_valid[STAGES][p];
      assign lvl_ready[STAGES][p]          = out_ready[p];
      assign out_tag[p*TAG_W +: TAG_W]     = lvl_pkt[STAGES][p][PKT_W-1 -: TAG_W];
      assign out_data[p*DATA_W +: DATA_W]  = lvl_pkt[STAGES][p][DATA_W-1:0];

      // R1: a packet waiting at port p is addressed to p.
      p_exit_tag_r1: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid[p] |-> (out_tag[p*TAG_W +: TAG_W] == TAG_W'(p)));
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      for (genvar j = 0; j < HALF; j++) begin : g_elem
         localparam int SRC_A = unshuffle_pos(2*j,     STAGES);
         localparam int SRC_B = unshuffle_pos(2*j + 1, STAGES);

         logic [1:0]            sw_in_valid, sw_in_ready, sw_out_valid, sw_out_ready;
         logic [1:0][PKT_W-1:0] sw_in_pkt, sw_out_pkt;

         assign sw_in_valid  = {lvl_valid[s][SRC_B], lvl_valid[s][SRC_A]};
         assign sw_in_pkt[0] = lvl_pkt[s][SRC_A];
         assign sw_in_pkt[1] = lvl_pkt[s][SRC_B];
         assign lvl_ready[s][SRC_A] = sw_in_ready[0];
         assign lvl_ready[s][SRC_B] = sw_in_ready[1];

         assign lvl_valid[s+1][2*j]     = sw_out_valid[0];
         assign lvl_valid[s+1][2*j + 1] = sw_out_valid[1];
         assign lvl_pkt[s+1][2*j]       = sw_out_pkt[0];
         assign lvl_pkt[s+1][2*j + 1]   = sw_out_pkt[1];
         assign sw_out_ready = {lvl_ready[s+1][2*j + 1], lvl_ready[s+1][2*j]};

         omega_switch #(
            .PKT_W      (PKT_W),
            .SEL_POS    (DATA_W + STAGES - 1 - s),
            .FIFO_DEPTH (FIFO_DEPTH)
         ) u_sw (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (sw_in_valid),
            .in_pkt    (sw_in_pkt),
            .in_ready  (sw_in_ready),
            .out_valid (sw_out_valid),
            .out_pkt   (sw_out_pkt),
            .out_ready (sw_out_ready)
         );
      end
   end
endmodule

// File: tb/omega_fabric_tb.sv
module omega_fabric_tb;
   localparam int N  = 8;
   localparam int TW = 3;
   localparam int DW = 8;
   localparam int NV = 8;

   // Destination of source s is bits [3*s +: 3].
   localparam logic [23:0] VEC [NV] = '{
      24'hFAC688,  // identity
      24'h053977,  // reversal
      24'h000000,  // all to port 0
      24'hB6DB6D,  // all to port 5
      24'h1F58D1,  // shift by one
      24'h9246DB,  // low half to 3, high half to 4
      24'h50FA33,  // permutation
      24'h8F11D5   // permutation
   };

   logic              clk = 1'b0;
   logic              rst_n;
   logic [N-1:0]      in_valid, in_ready, out_valid, out_ready;
   logic [N*TW-1:0]   in_tag, out_tag;
   logic [N*DW-1:0]   in_data, out_data;

   int n_checks = 0;
   int n_errors = 0;
   int dst_list [N][32];
   int n_pkts   [N];
   int idx      [N];
   int last_seq [N][N];
   int rx_cnt   [N];
   int total_rx;
   int arr_src  [64];
   logic [N-1:0] ready_mask;

   always #5 clk = ~clk;

   omega_fabric #(.N_PORTS(N), .DATA_W(DW), .FIFO_DEPTH(2)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_tag(in_tag), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_tag(out_tag), .out_data(out_data)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic clear_stim();
      for (int s = 0; s < N; s++) begin
         n_pkts[s] = 0;
         idx[s]    = 0;
         rx_cnt[s] = 0;
         for (int p = 0; p < N; p++) last_seq[s][p] = -1;
      end
      total_rx   = 0;
      ready_mask = '1;
   endtask

   task automatic add_pkt(input int src, input int dst);
      dst_list[src][n_pkts[src]] = dst;
      n_pkts[src]++;
   endtask

   task automatic collect(input int p);
      int tag, src, seq;
      tag = int'(out_tag[p*TW +: TW]);
      src = int'(out_data[p*DW+5 +: 3]);
      seq = int'(out_data[p*DW +: 5]);
      check(tag == p, "R1 exit port", p, tag);
      check(seq < n_pkts[src] && tag == dst_list[src][seq], "R2 tag/payload intact",
            tag, (seq < n_pkts[src]) ? dst_list[src][seq] : -1);
      check(seq > last_seq[src][p], "R8 per-source order", seq, last_seq[src][p] + 1);
      last_seq[src][p] = seq;
      rx_cnt[p]++;
      if (total_rx < 64) arr_src[total_rx] = src;
      total_rx++;
   endtask

   task automatic step();
      logic [N-1:0] acc;
      for (int s = 0; s < N; s++) begin
         if (idx[s] < n_pkts[s]) begin
            in_valid[s]            = 1'b1;
            in_tag[s*TW +: TW]     = TW'(dst_list[s][idx[s]]);
            in_data[s*DW +: DW]    = {3'(s), 5'(idx[s])};
         end else begin
            in_valid[s] = 1'b0;
         end
      end
      out_ready = ready_mask;
      #1;
      acc = in_valid & in_ready;
      for (int p = 0; p < N; p++) if (out_valid[p] && out_ready[p]) collect(p);
      @(posedge clk);
      @(negedge clk);
      for (int s = 0; s < N; s++) if (acc[s]) idx[s]++;
   endtask

   function automatic int total_tx();
      int t = 0;
      for (int s = 0; s < N; s++) t += n_pkts[s];
      return t;
   endfunction

   task automatic drain(input string req);
      int guard = 0;
      while (total_rx < total_tx() && guard < 500) begin
         step();
         guard++;
      end
      check(total_rx == total_tx(), req, total_rx, total_tx());
   endtask

   initial begin
      #2_000_000;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      rst_n     = 1'b0;
      in_valid  = '0;
      in_tag    = '0;
      in_data   = '0;
      out_ready = '0;
      clear_stim();
      repeat (3) @(negedge clk);
      check(out_valid == '0, "R6 out_valid in reset", int'(out_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == '0, "R6 out_valid after reset", int'(out_valid), 0);

      // R6: first offered packet accepted at once.
      in_valid[0] = 1'b1;
      in_tag[0 +: TW] = 3'd1;
      #1;
      check(in_ready[0] == 1'b1, "R6 accept after reset", int'(in_ready[0]), 1);
      in_valid = '0;

      // Vector table: one packet per source per vector.
      for (int v = 0; v < NV; v++) begin
         int exp_cnt [N];
         clear_stim();
         for (int p = 0; p < N; p++) exp_cnt[p] = 0;
         for (int s = 0; s < N; s++) begin
            add_pkt(s, int'(VEC[v][3*s +: 3]));
            exp_cnt[int'(VEC[v][3*s +: 3])]++;
         end
         drain("R3 all delivered");
         for (int p = 0; p < N; p++)
            check(rx_cnt[p] == exp_cnt[p], "R3 per-port count", rx_cnt[p], exp_cnt[p]);
      end

      // R7: unloaded latency of n = 3 edges, source 6 to port 2.
      clear_stim();
      add_pkt(6, 2);
      step();
      check(out_valid[2] == 1'b0, "R7 latency edge 1", int'(out_valid[2]), 0);
      step();
      check(out_valid[2] == 1'b0, "R7 latency edge 2", int'(out_valid[2]), 0);
      step();
      check(out_valid[2] == 1'b1, "R7 latency edge 3", int'(out_valid[2]), 1);
      drain("R7 delivered");

      // R4: sources 0 and 4 share the first element; stream 6 each to port 0.
      clear_stim();
      for (int k = 0; k < 6; k++) begin
         add_pkt(0, 0);
         add_pkt(4, 0);
      end
      drain("R4 all delivered");
      for (int k = 0; k < 10; k++)
         check(arr_src[k] != arr_src[k+1], "R4 alternating grants", arr_src[k+1], 4 - arr_src[k]);

      // R5: port 5 held not-ready while three sources send to it.
      clear_stim();
      ready_mask = 8'hFF & ~8'h20;
      for (int k = 0; k < 3; k++) begin
         add_pkt(1, 5);
         add_pkt(2, 5);
         add_pkt(3, 5);
      end
      repeat (30) step();
      begin
         logic [TW+DW-1:0] held;
         check(out_valid[5] == 1'b1, "R5 valid while blocked", int'(out_valid[5]), 1);
         held = {out_tag[5*TW +: TW], out_data[5*DW +: DW]};
         repeat (5) step();
         check({out_tag[5*TW +: TW], out_data[5*DW +: DW]} == held, "R5 head stable",
               int'({out_tag[5*TW +: TW], out_data[5*DW +: DW]}), int'(held));
         check(total_rx == 0, "R5 nothing taken", total_rx, 0);
      end
      ready_mask = '1;
      drain("R5 none lost after release");
      check(rx_cnt[5] == 9, "R5 count at port 5", rx_cnt[5], 9);

      // R9/R3: mixed streams with a held port, then release.
      clear_stim();
      ready_mask = 8'hFE;
      for (int k = 0; k < 4; k++) begin
         add_pkt(7, 0);
         add_pkt(5, 3);
         add_pkt(2, 6);
      end
      repeat (12) step();
      ready_mask = '1;
      drain("R9 mixed streams delivered");
      check(rx_cnt[0] == 4 && rx_cnt[3] == 4 && rx_cnt[6] == 4, "R9 port layout",
            rx_cnt[0] + rx_cnt[3] + rx_cnt[6], 12);

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule